// File: doc/BRIEF.md
# Fibre Channel Word Synchronization Monitor

This block watches one receive lane that has already been through 8b/10b decoding and comma alignment. On each clock where the word strobe is high it takes a 32-bit word and three 4-bit per-byte flag groups: control character, code violation (running disparity or invalid code), and comma found in the wrong position. From this stream it decides whether the lane has word synchronization.

After reset the lane is unsynchronized. It becomes synchronized once three idle ordered sets arrive back to back with no fault or other word between them. While synchronized, every faulty word adds one to a violation tally. Each run of two clean words in a row removes one from the tally. When four violations pile up, synchronization is dropped and the idle search starts again from zero. The lane state is driven on a sync output and also on a separately registered status bit that a register block can sample.

Top module: `fc_word_sync`

## Requirements
- R1: While reset is applied, and for the cycles after release until valid words arrive, both `sync_o` and `status_o` read 0.
- R2: A word is an idle ordered set only when bits [7:0] are 0xBC with `in_ctl[0]`=1, bits [15:8] are 0x95, bits [23:16] are 0xB5 and bits [31:24] are 0xB5, each of these three with its control flag 0. Any other byte value or control flag (including a comma in a lane other than 0) makes it a non-idle word.
- R3: Out of sync, the third back-to-back faultless idle sets `sync_o` high on the clock edge that samples that word.
- R4: Out of sync, a faulty word or any non-idle word resets the idle count to zero, so three fresh idles are then needed.
- R5: A word is faulty when any bit of `in_cv` or `in_mcomma` is 1. In sync, each faulty word adds one violation. The fourth outstanding violation clears `sync_o` on the edge that samples it.
- R6: In sync with a nonzero tally, every second clean word in a row removes one violation. A faulty word restarts the pairing.
- R7: Entering sync clears the tally and the pairing, so four fresh faulty words are needed to lose sync.
- R8: Words sampled while `in_vld` is 0 have no effect on sync state, idle count or tally.
- R9: `status_o` is 0 whenever the lane is out of sync and 1 whenever it is in sync, in the same cycle as `sync_o`.
- R10: After sync is lost, acquisition restarts from a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Word strobe; inputs are sampled only when 1 |
| in_word | input | 32 | Decoded word, byte lane 0 in bits [7:0] |
| in_ctl | input | 4 | Per-byte control character flag |
| in_cv | input | 4 | Per-byte code or running-disparity violation |
| in_mcomma | input | 4 | Per-byte misaligned comma flag |
| sync_o | output | 1 | Word synchronization achieved |
| status_o | output | 1 | Registered lane status bit, 1 when synchronized |

## Verification
The hardest state to reach is a violation tally sitting at three with the clean-word pairing half done, because the next word then decides between losing sync and recovering a credit. It is only reachable through an exact interleaving of faulty and clean words after acquisition. The bench therefore reacquires sync and then applies every ten-word pattern of faulty and clean words. It also sweeps every six-word mix of idles, data and both fault kinds during acquisition, comparing each cycle with an arithmetic model.

// File: rtl/fc_sync_pkg.sv
package fc_sync_pkg;

  localparam int unsigned LANE_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * LANE_BYTES;

  // Idle ordered set: comma character in lane 0 followed by three data chars
  localparam logic [WORD_W-1:0]     IDLE_WORD = {8'hB5, 8'hB5, 8'h95, 8'hBC};
  localparam logic [LANE_BYTES-1:0] IDLE_CTL  = 4'b0001;

  typedef enum logic {
    LNK_HUNT   = 1'b0,
    LNK_LOCKED = 1'b1
  } lnk_state_e;

endpackage

// File: rtl/fc_word_class.sv
module fc_word_class
  import fc_sync_pkg::*;
(
  input  logic [WORD_W-1:0]     word_i,
  input  logic [LANE_BYTES-1:0] ctl_i,
  input  logic [LANE_BYTES-1:0] cv_i,
  input  logic [LANE_BYTES-1:0] mcomma_i,
  output logic                  idle_o,
  output logic                  fault_o
);

  logic [LANE_BYTES-1:0] byte_match;
  logic [LANE_BYTES-1:0] byte_fault;

  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_lane
    always_comb begin
      byte_match[b] = (word_i[8*b +: 8] == IDLE_WORD[8*b +: 8]) &&
                      (ctl_i[b] == IDLE_CTL[b]);
      byte_fault[b] = cv_i[b] | mcomma_i[b];
    end
  end

  always_comb begin
    fault_o = |byte_fault;
    idle_o  = (&byte_match) & ~fault_o;
  end

endmodule

// File: rtl/fc_acq_counter.sv
module fc_acq_counter #(
  parameter int unsigned ACQ_IDLES = 3
) (
  input  logic clk,
  input  logic rst_q,
  input  logic hunt_i,
  input  logic vld_i,
  input  logic idle_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(ACQ_IDLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ACQ_IDLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = vld_i | ~hunt_i;
    done_o = hunt_i & vld_i & idle_i & (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (!hunt_i)           cnt_d = '0;
    else if (!idle_i)      cnt_d = '0;
    else if (done_o)       cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_ACQ_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= LAST);                                                   // R3
  AST_ACQ_RESTART: assert property (@(posedge clk) disable iff (!rst_q)
    (hunt_i && vld_i && !idle_i) |=> (cnt_q == '0));                  // R4
  AST_ACQ_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (hunt_i && !vld_i) |=> $stable(cnt_q));                           // R8

endmodule

// File: rtl/fc_viol_tracker.sv
module fc_viol_tracker #(
  parameter int unsigned LOSS_VIOLS = 4
) (
  input  logic clk,
  input  logic rst_q,
  input  logic locked_i,
  input  logic vld_i,
  input  logic fault_i,
  output logic lost_o
);

  localparam int unsigned VW = $clog2(LOSS_VIOLS + 1);
  localparam logic [VW-1:0] VLAST = VW'(LOSS_VIOLS - 1);

  logic [VW-1:0] viol_q, viol_d;
  logic          pair_q, pair_d;
  logic          upd_en;

  always_comb begin
    upd_en = vld_i | ~locked_i;
    lost_o = locked_i & vld_i & fault_i & (viol_q == VLAST);
    viol_d = viol_q;
    pair_d = pair_q;
    if (!locked_i) begin
      viol_d = '0;
      pair_d = 1'b0;
    end else if (fault_i) begin
      pair_d = 1'b0;
      viol_d = lost_o ? '0 : viol_q + 1'b1;
    end else if (viol_q != '0) begin
      if (pair_q) begin
        viol_d = viol_q - 1'b1;
        pair_d = 1'b0;
      end else begin
        pair_d = 1'b1;
      end
    end else begin
      pair_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      viol_q <= '0;
      pair_q <= 1'b0;
    end else if (upd_en) begin
      viol_q <= viol_d;
      pair_q <= pair_d;
    end
  end

  AST_VIOL_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    viol_q <= VLAST);                                                 // R5
  AST_PAIR_CREDIT: assert property (@(posedge clk) disable iff (!rst_q)
    (locked_i && vld_i && !fault_i && pair_q) |=> (viol_q < $past(viol_q))); // R6
  AST_CLEAR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_q)
    !locked_i |=> (viol_q == '0 && !pair_q));                         // R7
  AST_PAIR_NEEDS_VIOL: assert property (@(posedge clk) disable iff (!rst_q)
    pair_q |-> (viol_q != '0));                                       // R6

endmodule

// File: rtl/fc_word_sync.sv
module fc_word_sync
  import fc_sync_pkg::*;
#(
  parameter int unsigned ACQ_IDLES  = 3,
  parameter int unsigned LOSS_VIOLS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [WORD_W-1:0]     in_word,
  input  logic [LANE_BYTES-1:0] in_ctl,
  input  logic [LANE_BYTES-1:0] in_cv,
  input  logic [LANE_BYTES-1:0] in_mcomma,
  output logic                  sync_o,
  output logic                  status_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic       is_idle, is_fault;
  logic       acq_done, lost;
  logic       hunting, locked;
  lnk_state_e state_q, state_d;
  logic       status_q;

  fc_word_class u_class (
    .word_i   (in_word),
    .ctl_i    (in_ctl),
    .cv_i     (in_cv),
    .mcomma_i (in_mcomma),
    .idle_o   (is_idle),
    .fault_o  (is_fault)
  );

  always_comb begin
    hunting = (state_q == LNK_HUNT);
    locked  = (state_q == LNK_LOCKED);
  end

  fc_acq_counter #(.ACQ_IDLES(ACQ_IDLES)) u_acq (
    .clk    (clk),
    .rst_q  (rst_q),
    .hunt_i (hunting),
    .vld_i  (in_vld),
    .idle_i (is_idle),
    .done_o (acq_done)
  );

  fc_viol_tracker #(.LOSS_VIOLS(LOSS_VIOLS)) u_viol (
    .clk      (clk),
    .rst_q    (rst_q),
    .locked_i (locked),
    .vld_i    (in_vld),
    .fault_i  (is_fault),
    .lost_o   (lost)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LNK_HUNT:   if (acq_done) state_d = LNK_LOCKED;
      LNK_LOCKED: if (lost)     state_d = LNK_HUNT;
      default:                  state_d = LNK_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= LNK_HUNT;
      status_q <= 1'b0;
    end else if (in_vld) begin
      state_q  <= state_d;
      status_q <= (state_d == LNK_LOCKED);
    end
  end

  assign sync_o   = (state_q == LNK_LOCKED);
  assign status_o = status_q;

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_q)
    status_o == sync_o);                                              // R9
  AST_RISE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(sync_o) |-> ($past(in_vld) && $past(is_idle)));             // R3
  AST_FALL_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(sync_o) |-> ($past(in_vld) && $past(is_fault)));            // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |=> $stable(sync_o));                                     // R8

endmodule

// File: tb/fc_word_sync_test.sv
module fc_word_sync_test;

  localparam int K_IDLE = 0, K_DATA = 1, K_CV = 2, K_MC = 3;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] in_word;
  logic [3:0]  in_ctl, in_cv, in_mcomma;
  logic        sync_o, status_o;

  int checks, errors;
  int m_sync, m_acq, m_viol, m_pair;

  fc_word_sync uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .in_ctl(in_ctl), .in_cv(in_cv), .in_mcomma(in_mcomma),
    .sync_o(sync_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_vld = 1'b0; in_word = '0; in_ctl = '0; in_cv = '0; in_mcomma = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_sync = 0; m_acq = 0; m_viol = 0; m_pair = 0;
  endtask

  // model of R3..R7 and R10
  task automatic model(input int idle, input int bad);
    if (m_sync == 0) begin
      if (bad != 0 || idle == 0) m_acq = 0;
      else if (m_acq == 2) begin m_sync = 1; m_acq = 0; m_viol = 0; m_pair = 0; end
      else m_acq++;
    end else if (bad != 0) begin
      m_pair = 0;
      if (m_viol == 3) begin m_sync = 0; m_viol = 0; m_acq = 0; end
      else m_viol++;
    end else if (m_viol != 0) begin
      if (m_pair != 0) begin m_viol--; m_pair = 0; end
      else m_pair = 1;
    end
  endtask

  // drive one word: kind, lane for fault, strobe; then compare
  task automatic word(input int kind, input int lane, input logic vld,
                      input logic [31:0] w, input logic [3:0] c, input int raw);
    string tag;
    int idle, bad;
    @(negedge clk);
    in_vld = vld; in_cv = '0; in_mcomma = '0;
    if (raw != 0) begin in_word = w; in_ctl = c; end
    else if (kind == K_DATA) begin in_word = 32'h1234_5678; in_ctl = 4'b0000; end
    else begin in_word = 32'hB5B5_95BC; in_ctl = 4'b0001; end
    if (kind == K_CV) in_cv[lane] = 1'b1;
    if (kind == K_MC) in_mcomma[lane] = 1'b1;
    idle = (raw == 0 && kind != K_DATA && kind == K_IDLE) ? 1 : 0;
    if (raw != 0) idle = (w == 32'hB5B5_95BC && c == 4'b0001) ? 1 : 0;
    bad  = (kind == K_CV || kind == K_MC) ? 1 : 0;
    if (vld == 1'b0) tag = "R8";
    else if (raw != 0) tag = "R2";
    else if (m_sync == 0) tag = (idle != 0 && bad == 0) ? "R3" : "R4";
    else tag = bad != 0 ? "R5" : "R6";
    if (vld) model(idle, bad);
    @(posedge clk);
    #2;
    check(tag, int'(sync_o), m_sync);
    check("R9", int'(status_o), m_sync);
  endtask

  task automatic lock();
    for (int i = 0; i < 3; i++) word(K_IDLE, 0, 1'b1, '0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    do_reset();
    check("R1", int'(sync_o), 0);
    check("R1", int'(status_o), 0);

    // R2: near-idle words never count
    lock(); do_reset();
    word(K_IDLE, 0, 1'b1, '0, '0, 0); word(K_IDLE, 0, 1'b1, '0, '0, 0);
    word(K_DATA, 0, 1'b1, 32'hB5B5_95BC, 4'b0000, 1);
    word(K_IDLE, 0, 1'b1, '0, '0, 0); word(K_IDLE, 0, 1'b1, '0, '0, 0);
    word(K_DATA, 0, 1'b1, 32'hB5B5_94BC, 4'b0001, 1);
    word(K_IDLE, 0, 1'b1, '0, '0, 0); word(K_IDLE, 0, 1'b1, '0, '0, 0);
    word(K_DATA, 0, 1'b1, 32'hB595_BCB5, 4'b0010, 1);
    word(K_IDLE, 0, 1'b1, '0, '0, 0); word(K_IDLE, 0, 1'b1, '0, '0, 0);
    word(K_DATA, 0, 1'b1, 32'hB5B5_95BC, 4'b0011, 1);
    check("R2", int'(sync_o), 0);

    // R8: faults without strobe while locked, and idles without strobe while hunting
    do_reset();
    lock();
    for (int i = 0; i < 6; i++) word(K_CV, i % 4, 1'b0, '0, '0, 0);
    check("R8", int'(sync_o), 1);
    do_reset();
    for (int i = 0; i < 4; i++) word(K_IDLE, 0, 1'b0, '0, '0, 0);
    check("R8", int'(sync_o), 0);

    // R7 and R10: lose, relock, tally starts fresh
    do_reset();
    lock();
    for (int i = 0; i < 3; i++) word(K_MC, i, 1'b1, '0, '0, 0);
    word(K_CV, 3, 1'b1, '0, '0, 0);
    check("R5", int'(sync_o), 0);
    word(K_IDLE, 0, 1'b1, '0, '0, 0); word(K_IDLE, 0, 1'b1, '0, '0, 0);
    check("R10", int'(sync_o), 0);
    word(K_IDLE, 0, 1'b1, '0, '0, 0);
    check("R10", int'(sync_o), 1);
    for (int i = 0; i < 3; i++) word(K_CV, 1, 1'b1, '0, '0, 0);
    check("R7", int'(sync_o), 1);
    word(K_CV, 2, 1'b1, '0, '0, 0);
    check("R7", int'(sync_o), 0);

    // acquisition sweep: every 6-word mix of four kinds
    for (int p = 0; p < 4096; p++) begin
      do_reset();
      for (int s = 0; s < 6; s++) word((p >> (2 * s)) & 3, s % 4, 1'b1, '0, '0, 0);
    end

    // locked sweep: every 10-word pattern of clean and faulty words
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      lock();
      for (int s = 0; s < 10; s++)
        word(((p >> s) & 1) != 0 ? ((s & 1) != 0 ? K_MC : K_CV) : K_DATA, s % 4, 1'b1, '0, '0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule